// File: doc/BRIEF.md
# Rising-Edge Aligned Duty Cycle Meter

This block measures how long a slow digital input stays high and how long it then stays low, counting in units of a tick enable rather than raw clock cycles. The input is asynchronous to the block clock, so it first passes through a synchroniser. After reset the block discards whatever phase is already in progress. It waits out the current high level, then the current low level, so the first measured high phase always begins on a clean rising edge.

From then on the block measures without gaps. Each rising edge closes one period, publishes its high and low tick counts together with a one-cycle valid pulse, and opens the next period with fresh counters. A typical use is decoding a duty-cycle-encoded sensor output. The downstream logic converts the count pair into a physical quantity.

The result interface is a plain strobe and not a valid/ready stream: the block cannot pause a physical signal, so it offers no back-pressure. A consumer must capture the counts on the valid cycle or at any time before the next pulse, because the outputs hold their values until then.

Top module: `duty_meter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `valid` is 0 and both count outputs are 0.
- R2: A high or low phase that is already in progress when reset is released is never reported. The first result describes the first complete high phase that follows a low level, and no `valid` pulse occurs before that period ends.
- R3: `high_count` equals the number of clock cycles with `tick_en` = 1 during which the synchronised input was high in the measured period. With `tick_en` held at 0 it is 0. With `tick_en` = 1 on every fourth cycle it equals the high length divided by 4, when that length is a multiple of 4.
- R4: `low_count` follows the same rule as R3 for the low phase that follows the measured high phase.
- R5: Both counters restart from zero at every rising edge, so nothing from one period carries into the next period's result.
- R6: A count that would exceed 2^CNT_W - 1 stays at 2^CNT_W - 1 instead of wrapping.
- R7: `valid` is a single-cycle pulse. It is high in the clock cycle that follows the third rising clock edge after the input rises: two synchroniser stages plus one output register.
- R8: Between valid pulses, `high_count` and `low_count` hold their last published values.
- R9: After alignment, every rising edge of the input ends one period and starts the next one, so each complete high-then-low period yields exactly one result, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_async | input | 1 | Signal under measurement, asynchronous to clk |
| tick_en | input | 1 | Time-base enable; one count per cycle in which it is high |
| high_count | output | CNT_W | Ticks counted during the last complete high phase |
| low_count | output | CNT_W | Ticks counted during the low phase that followed it |
| valid | output | 1 | One-cycle pulse marking a new count pair |

## Verification
A wrong alignment state shows as an early `valid` or as a first result that carries the length of the discarded partial phase. This appears at the very first pulse after reset. A counter that is not cleared, or that wraps, shows as a wrong count pair on the `valid` pulse that ends the affected period, at the latest one input period later. A fault in the publish path shows either as a pulse at the wrong cycle relative to the input edge or as outputs that drift between pulses. The checks compare timing and values at every cycle, so either fault is caught within a cycle of its occurrence.

// File: rtl/duty_meter_pkg.sv
package duty_meter_pkg;

  typedef enum logic [1:0] {
    PH_SKIP_HI = 2'd0,
    PH_SKIP_LO = 2'd1,
    PH_MEAS_HI = 2'd2,
    PH_MEAS_LO = 2'd3
  } phase_e;

endpackage

// File: rtl/duty_meter_sync.sv
module duty_meter_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/duty_meter_satcnt.sv
module duty_meter_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             seed,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                      count <= '0;
    else if (clear)               count <= {{(CNT_W-1){1'b0}}, seed};
    else if (inc && count != TOP) count <= count + 1'b1;
  end

endmodule

// File: rtl/duty_meter_fsm.sv
module duty_meter_fsm
  import duty_meter_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   lvl,
  input  logic   tick,
  output phase_e state,
  output logic   hi_clr,
  output logic   hi_seed,
  output logic   hi_inc,
  output logic   lo_clr,
  output logic   lo_seed,
  output logic   lo_inc,
  output logic   publish
);

  phase_e nxt;

  always_comb begin
    nxt     = state;
    hi_clr  = 1'b0;
    hi_seed = 1'b0;
    hi_inc  = 1'b0;
    lo_clr  = 1'b0;
    lo_seed = 1'b0;
    lo_inc  = 1'b0;
    publish = 1'b0;
    unique case (state)
      PH_SKIP_HI: if (!lvl) nxt = PH_SKIP_LO;
      PH_SKIP_LO: begin
        if (lvl) begin
          nxt     = PH_MEAS_HI;
          hi_clr  = 1'b1;
          hi_seed = tick;
          lo_clr  = 1'b1;
        end
      end
      PH_MEAS_HI: begin
        if (!lvl) begin
          nxt     = PH_MEAS_LO;
          lo_clr  = 1'b1;
          lo_seed = tick;
        end else begin
          hi_inc = tick;
        end
      end
      PH_MEAS_LO: begin
        if (lvl) begin
          nxt     = PH_MEAS_HI;
          publish = 1'b1;
          hi_clr  = 1'b1;
          hi_seed = tick;
          lo_clr  = 1'b1;
        end else begin
          lo_inc = tick;
        end
      end
      default: nxt = PH_SKIP_HI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PH_SKIP_HI;
    else     state <= nxt;
  end

endmodule

// File: rtl/duty_meter.sv
module duty_meter
  import duty_meter_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_async,
  input  logic             tick_en,
  output logic [CNT_W-1:0] high_count,
  output logic [CNT_W-1:0] low_count,
  output logic             valid
);

  logic             lvl_s;
  phase_e           state_q;
  logic             hi_clr, hi_seed, hi_inc;
  logic             lo_clr, lo_seed, lo_inc;
  logic             publish;
  logic [CNT_W-1:0] hi_cnt, lo_cnt;

  // Reset value 1: a spurious early high only prolongs the skip-high wait.
  duty_meter_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (sig_async),
    .q_sync  (lvl_s)
  );

  duty_meter_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .lvl     (lvl_s),
    .tick    (tick_en),
    .state   (state_q),
    .hi_clr  (hi_clr),
    .hi_seed (hi_seed),
    .hi_inc  (hi_inc),
    .lo_clr  (lo_clr),
    .lo_seed (lo_seed),
    .lo_inc  (lo_inc),
    .publish (publish)
  );

  duty_meter_satcnt #(.CNT_W(CNT_W)) u_hi_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (hi_clr),
    .seed  (hi_seed),
    .inc   (hi_inc),
    .count (hi_cnt)
  );

  duty_meter_satcnt #(.CNT_W(CNT_W)) u_lo_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (lo_clr),
    .seed  (lo_seed),
    .inc   (lo_inc),
    .count (lo_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      high_count <= '0;
      low_count  <= '0;
      valid      <= 1'b0;
    end else begin
      valid <= publish;
      if (publish) begin
        high_count <= hi_cnt;
        low_count  <= lo_cnt;
      end
    end
  end

endmodule

// File: rtl/duty_meter_chk.sv
module duty_meter_chk
  import duty_meter_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             lvl,
  input phase_e           state,
  input logic [CNT_W-1:0] hi_cnt,
  input logic [CNT_W-1:0] lo_cnt,
  input logic [CNT_W-1:0] high_count,
  input logic [CNT_W-1:0] low_count,
  input logic             valid
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  a_r7_valid_after_low: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(state) == PH_MEAS_LO);

  a_r8_hold_outputs: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(high_count) && $stable(low_count)));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (state == PH_MEAS_HI && lvl && hi_cnt == TOP) |=> hi_cnt == TOP);

  a_r6_no_wrap_low: assert property (@(posedge clk) disable iff (rst)
    (state == PH_MEAS_LO && !lvl && lo_cnt == TOP) |=> lo_cnt == TOP);

  a_r5_fresh_start: assert property (@(posedge clk) disable iff (rst)
    (state == PH_MEAS_HI && $past(state) != PH_MEAS_HI) |->
      (lo_cnt == '0 && hi_cnt <= 1));

  a_r2_no_early_valid: assert property (@(posedge clk) disable iff (rst)
    (state == PH_SKIP_HI || state == PH_SKIP_LO) |=> !valid);

endmodule

bind duty_meter duty_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lvl        (lvl_s),
  .state      (state_q),
  .hi_cnt     (hi_cnt),
  .lo_cnt     (lo_cnt),
  .high_count (high_count),
  .low_count  (low_count),
  .valid      (valid)
);

// File: tb/duty_meter_test.sv
`timescale 1ns/1ps
module duty_meter_test;

  localparam int W   = 6;
  localparam int TOP = (1 << W) - 1;

  typedef struct {
    int     h;
    int     l;
    longint at;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sig = 1'b1;
  logic         tick = 1'b0;
  logic [W-1:0] hc, lc;
  logic         vld;

  int     total = 0;
  int     bad   = 0;
  longint cyc   = 0;
  int     tick_mode = 1;
  bit     done = 0;
  exp_t   q[$];
  bit     have_pend = 0;
  int     pend_h, pend_l;
  logic [W-1:0] last_h = '0, last_l = '0;

  duty_meter #(.CNT_W(W), .SYNC_STAGES(2)) uut (
    .clk        (clk),
    .rst        (rst),
    .sig_async  (sig),
    .tick_en    (tick),
    .high_count (hc),
    .low_count  (lc),
    .valid      (vld)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    case (tick_mode)
      0:       tick = 1'b0;
      1:       tick = 1'b1;
      default: tick = (cyc % 4 == 0);
    endcase
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_cnt(int n);
    int v;
    case (tick_mode)
      0:       v = 0;
      1:       v = n;
      default: v = n / 4;
    endcase
    return (v > TOP) ? TOP : v;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      last_h = '0;
      last_l = '0;
    end else if (vld) begin
      if (q.size() == 0) begin
        chk(0, "R2 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(hc == e.h, "R3 high count", hc, e.h);
        chk(lc == e.l, "R4 low count", lc, e.l);
        chk(cyc == e.at, "R7 valid cycle", cyc, e.at);
      end
      last_h = hc;
      last_l = lc;
    end else begin
      if (hc != last_h || lc != last_l)
        chk(0, "R8 outputs held", {hc, lc}, {last_h, last_l});
    end
  end

  task automatic hold(bit lvl, int n);
    sig = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic rise_mark();
    exp_t e;
    if (have_pend) begin
      e.h = pend_h;
      e.l = pend_l;
      e.at = cyc + 3;
      q.push_back(e);
    end
  endtask

  task automatic period(int h, int l);
    rise_mark();
    hold(1'b1, h);
    hold(1'b0, l);
    pend_h = expect_cnt(h);
    pend_l = expect_cnt(l);
    have_pend = 1;
  endtask

  task automatic close_group(string tag);
    rise_mark();
    have_pend = 0;
    hold(1'b1, 6);
    chk(q.size() == 0, tag, q.size(), 0);
  endtask

  task automatic do_reset(bit lvl, int mode);
    @(negedge clk);
    rst = 1'b1;
    sig = lvl;
    tick_mode = mode;
    repeat (3) @(negedge clk);
    chk(vld == 1'b0 && hc == '0 && lc == '0, "R1 reset outputs", {vld, hc, lc}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(vld == 1'b0 && hc == '0 && lc == '0, "R1 after release", {vld, hc, lc}, 0);
  endtask

  initial begin
    // Group A: input high at reset, partial high and low discarded (R2, R3, R4, R5)
    do_reset(1'b1, 1);
    hold(1'b1, 5);
    hold(1'b0, 7);
    period(10, 6);
    period(3, 12);
    period(25, 4);
    period(1, 1);
    period(2, 9);
    close_group("R9 group A all delivered");

    // Group B: input low at reset, partial low discarded (R2, R9)
    do_reset(1'b0, 1);
    hold(1'b0, 6);
    period(8, 9);
    period(5, 5);
    close_group("R9 group B all delivered");

    // Group C: saturation (R6)
    do_reset(1'b0, 1);
    hold(1'b0, 3);
    period(80, 10);
    period(63, 64);
    period(2, 3);
    close_group("R6 group C all delivered");

    // Group D: no ticks, counts stay zero (R3, R4)
    do_reset(1'b0, 0);
    hold(1'b0, 2);
    period(7, 7);
    period(12, 3);
    close_group("R3 group D all delivered");

    // Group E: tick every fourth cycle (R3, R4, R5)
    do_reset(1'b0, 2);
    hold(1'b0, 4);
    period(12, 8);
    period(4, 16);
    period(20, 4);
    close_group("R4 group E all delivered");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule